// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block keeps a small direct-mapped, write-through cache coherent with its peers on a shared atomic bus. Each line is one data word and carries one of two coherence states, present or absent, kept for the whole line. A local processor sends loads and stores through a request port. Loads that find their line are answered in the same cycle. A load that misses asks the bus arbiter for the bus, issues a read, and waits for the memory response that matches its address. Every store goes to the bus as a write. A store that finds its line also updates the local copy. A store that misses leaves the cache unchanged.

The controller watches every bus command through a snoop port. A write from another agent that hits a present line makes that line absent. Reads from any agent and the block's own writes change nothing. The processor-side state machine has three states. ST_IDLE accepts requests. ST_ARB holds the bus request until grant. ST_FILL waits for read data. The transitions are as follows. IDLE goes to ARB on any store or on a load miss. ARB goes to IDLE on grant for a store, and to FILL on grant for a load. FILL goes to IDLE when the matching response arrives. A load hit stays in IDLE.

Address bits [IDX_W-1:0] select the line and the upper bits form the tag. On the bus command port, `bus_cmd_write` = 1 means a write and 0 means a read.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is absent, `cpu_req_ready` is 1, and `bus_req`, `bus_cmd_valid` and `cpu_rdata_valid` are 0. The first load to any address misses.
- R2: A load whose line is present (same index, equal tag) raises `cpu_rdata_valid` with the stored word in the same cycle and raises no `bus_req`.
- R3: A load miss raises `bus_req` from the next cycle. On `bus_gnt` it drives `bus_cmd_valid` for exactly one cycle with `bus_cmd_write` = 0, the load address and `bus_cmd_id` = MY_ID.
- R4: While a read is outstanding, a response whose `rsp_addr` differs from the pending address is ignored. The matching response raises `cpu_rdata_valid` with `rsp_data` in that cycle and installs the line as present.
- R5: Every store, hit or miss, raises `bus_req`. On grant it drives one write command (`bus_cmd_write` = 1) that carries the store address and data, then returns to ready.
- R6: A store miss allocates nothing, so a later load to that address misses.
- R7: A store hit writes the store data into the local line as the write command issues. The line stays present and a later load hits with the new data.
- R8: A snooped write (`snp_write` = 1) from an agent whose `snp_id` differs from MY_ID makes a present line with a matching tag absent.
- R9: A snooped read, a snooped write that carries MY_ID, and a snooped write with a mismatched tag each leave the cache unchanged.
- R10: `cpu_req_ready` is 0 while waiting for grant or for fill data. Only one bus transaction is outstanding at a time, and a command is driven only in a cycle with `bus_gnt` high.
- R11: A foreign write snooped to the index being filled, during the fill wait, does not disturb the fill. The matching response still returns its data and leaves the line present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Request word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Request accepted this cycle (IDLE) |
| cpu_rdata_valid | output | 1 | Load data returned this cycle |
| cpu_rdata | output | DATA_W | Load data |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the bus arbiter |
| bus_cmd_valid | output | 1 | Command driven on the bus this cycle |
| bus_cmd_write | output | 1 | 1 = write, 0 = read |
| bus_cmd_addr | output | ADDR_W | Command address |
| bus_cmd_data | output | DATA_W | Write data |
| bus_cmd_id | output | ID_W | Originator identifier (MY_ID) |
| snp_valid | input | 1 | Bus command observed |
| snp_write | input | 1 | Observed command is a write |
| snp_id | input | ID_W | Originator of observed command |
| snp_addr | input | ADDR_W | Address of observed command |
| rsp_valid | input | 1 | Memory read response on the bus |
| rsp_addr | input | ADDR_W | Address of the response |
| rsp_data | input | DATA_W | Line data of the response |

## Verification
The bound checker checks the following on every cycle:
- commands appear only under grant and last one cycle;
- `bus_req` excludes `cpu_req_ready`;
- a hit answer never coincides with bus activity;
- a fill answer coincides with a response;
- a write command returns to ready while a read command does not.

Only the bench's scenarios can show that data and state persist across operations, because that needs a history of the cache contents. This covers:
- the no-allocate rule for store misses;
- local update on a store hit;
- invalidation by foreign writes but not by own writes or reads;
- replacement on an index conflict;
- a clean fill while a snoop hits the same index.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_FILL = 2'd2
    } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
// Tag, data and presence storage; one lookup port for the processor side,
// one for snooping, one install/update port and one invalidate port.
module wtc_line_store #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_valid,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_idx,
    output logic              sn_valid,
    output logic [TAG_W-1:0]  sn_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0]  present;
    logic [TAG_W-1:0]  tags  [LINES];
    logic [DATA_W-1:0] words [LINES];

    // Presence bit per line: an install wins over an invalidate on the same line.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                present[g] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                present[g] <= 1'b1;
            end else if (inv_en && inv_idx == IDX_W'(g)) begin
                present[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx]  <= wr_tag;
            words[wr_idx] <= wr_data;
        end
    end

    assign lk_valid = present[lk_idx];
    assign lk_tag   = tags[lk_idx];
    assign lk_data  = words[lk_idx];
    assign sn_valid = present[sn_idx];
    assign sn_tag   = tags[sn_idx];
endmodule

// File: rtl/wtc_snooper.sv
// Decides whether an observed bus command removes a local line.
module wtc_snooper #(
    parameter int          ADDR_W = 16,
    parameter int          IDX_W  = 3,
    parameter int          ID_W   = 2,
    parameter int unsigned MY_ID  = 1
) (
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  sn_idx,
    input  logic              sn_valid,
    input  logic [ADDR_W-IDX_W-1:0] sn_tag,
    output logic              inv_en,
    output logic [IDX_W-1:0]  inv_idx
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic foreign_wr;
    logic tag_hit;

    assign sn_idx     = snp_addr[IDX_W-1:0];
    assign foreign_wr = snp_valid && snp_write && (snp_id != ID_W'(MY_ID));
    assign tag_hit    = sn_valid && (sn_tag == snp_addr[ADDR_W-1 -: TAG_W]);
    assign inv_en     = foreign_wr && tag_hit;
    assign inv_idx    = sn_idx;
endmodule

// File: rtl/wtc_cpu_fsm.sv
// Processor-side sequencer: hit service, bus request, command issue, fill.
module wtc_cpu_fsm
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_rdata_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [DATA_W-1:0] bus_cmd_data,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_valid,
    input  logic [ADDR_W-IDX_W-1:0] lk_tag,
    input  logic [DATA_W-1:0] lk_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic [DATA_W-1:0] wr_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    wtc_state_e        state, state_nx;
    logic              p_write;
    logic [ADDR_W-1:0] p_addr;
    logic [DATA_W-1:0] p_data;
    logic [ADDR_W-1:0] sel_addr;
    logic              hit;
    logic              take;

    assign sel_addr = (state == ST_IDLE) ? cpu_req_addr : p_addr;
    assign lk_idx   = sel_addr[IDX_W-1:0];
    assign hit      = lk_valid && (lk_tag == sel_addr[ADDR_W-1 -: TAG_W]);

    // State and pending-request registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            p_write <= 1'b0;
            p_addr  <= '0;
            p_data  <= '0;
        end else begin
            state <= state_nx;
            if (take) begin
                p_write <= cpu_req_write;
                p_addr  <= cpu_req_addr;
                p_data  <= cpu_req_wdata;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        state_nx        = state;
        take            = 1'b0;
        cpu_req_ready   = 1'b0;
        cpu_rdata_valid = 1'b0;
        cpu_rdata       = '0;
        bus_req         = 1'b0;
        bus_cmd_valid   = 1'b0;
        bus_cmd_write   = 1'b0;
        bus_cmd_addr    = '0;
        bus_cmd_data    = '0;
        wr_en           = 1'b0;
        wr_idx          = p_addr[IDX_W-1:0];
        wr_tag          = p_addr[ADDR_W-1 -: TAG_W];
        wr_data         = p_data;
        unique case (state)
            ST_IDLE: begin
                cpu_req_ready = 1'b1;
                if (cpu_req_valid) begin
                    if (!cpu_req_write && hit) begin
                        cpu_rdata_valid = 1'b1;
                        cpu_rdata       = lk_data;
                    end else begin
                        take     = 1'b1;
                        state_nx = ST_ARB;
                    end
                end
            end
            ST_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_cmd_valid = 1'b1;
                    bus_cmd_write = p_write;
                    bus_cmd_addr  = p_addr;
                    bus_cmd_data  = p_write ? p_data : '0;
                    if (p_write) begin
                        wr_en    = hit;
                        state_nx = ST_IDLE;
                    end else begin
                        state_nx = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (rsp_valid && rsp_addr == p_addr) begin
                    cpu_rdata_valid = 1'b1;
                    cpu_rdata       = rsp_data;
                    wr_en           = 1'b1;
                    wr_data         = rsp_data;
                    state_nx        = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
    parameter int          ADDR_W = 16,
    parameter int          DATA_W = 32,
    parameter int          IDX_W  = 3,
    parameter int          ID_W   = 2,
    parameter int unsigned MY_ID  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_rdata_valid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    output logic [DATA_W-1:0] bus_cmd_data,
    output logic [ID_W-1:0]   bus_cmd_id,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  lk_idx, sn_idx, wr_idx, inv_idx;
    logic              lk_valid, sn_valid, wr_en, inv_en;
    logic [TAG_W-1:0]  lk_tag, sn_tag, wr_tag;
    logic [DATA_W-1:0] lk_data, wr_data;

    assign bus_cmd_id = ID_W'(MY_ID);

    wtc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .sn_idx(sn_idx), .sn_valid(sn_valid), .sn_tag(sn_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
        .inv_en(inv_en), .inv_idx(inv_idx)
    );

    wtc_snooper #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)) snoop_i (
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_id(snp_id),
        .snp_addr(snp_addr), .sn_idx(sn_idx), .sn_valid(sn_valid),
        .sn_tag(sn_tag), .inv_en(inv_en), .inv_idx(inv_idx)
    );

    wtc_cpu_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) fsm_i (
        .clk(clk), .rst(rst),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_req_ready(cpu_req_ready), .cpu_rdata_valid(cpu_rdata_valid),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_cmd_valid(bus_cmd_valid), .bus_cmd_write(bus_cmd_write),
        .bus_cmd_addr(bus_cmd_addr), .bus_cmd_data(bus_cmd_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag), .lk_data(lk_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data)
    );
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
    parameter int          ID_W  = 2,
    parameter int unsigned MY_ID = 1
) (
    input logic            clk,
    input logic            rst,
    input logic            cpu_req_ready,
    input logic            cpu_rdata_valid,
    input logic            bus_req,
    input logic            bus_gnt,
    input logic            bus_cmd_valid,
    input logic            bus_cmd_write,
    input logic [ID_W-1:0] bus_cmd_id,
    input logic            rsp_valid
);
    // R10: a command only appears under grant
    p_cmd_under_gnt_r10: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |-> bus_gnt);
    // R10: waiting for the bus means the processor port is stalled
    p_stall_while_req_r10: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> !cpu_req_ready);
    // R3: a command lasts a single cycle
    p_cmd_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |=> !bus_cmd_valid);
    // R3: a read command leaves the port stalled for the fill
    p_read_waits_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_valid && !bus_cmd_write) |=> !cpu_req_ready);
    // R5: a write command completes the store
    p_write_done_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_valid && bus_cmd_write) |=> cpu_req_ready);
    // R3: commands carry this agent's identifier
    p_own_id_r3: assert property (@(posedge clk) disable iff (rst)
        bus_cmd_valid |-> (bus_cmd_id == ID_W'(MY_ID)));
    // R2: a hit answer causes no bus activity
    p_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdata_valid && cpu_req_ready) |-> (!bus_req && !bus_cmd_valid));
    // R4: a fill answer needs a response on the bus
    p_fill_has_rsp_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_rdata_valid && !cpu_req_ready) |-> rsp_valid);
endmodule

bind wt_snoop_cache wtc_checker #(.ID_W(ID_W), .MY_ID(MY_ID)) chk_i (
    .clk(clk), .rst(rst), .cpu_req_ready(cpu_req_ready),
    .cpu_rdata_valid(cpu_rdata_valid), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd_valid(bus_cmd_valid), .bus_cmd_write(bus_cmd_write),
    .bus_cmd_id(bus_cmd_id), .rsp_valid(rsp_valid)
);

// File: tb/wt_snoop_cache_tb_top.sv
`timescale 1ns/100ps
module wt_snoop_cache_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;
    localparam int ID_W   = 2;
    localparam int MY_ID  = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic              cpu_req_valid = 0, cpu_req_write = 0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_req_ready, cpu_rdata_valid;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req, bus_gnt = 0;
    logic              bus_cmd_valid, bus_cmd_write;
    logic [ADDR_W-1:0] bus_cmd_addr;
    logic [DATA_W-1:0] bus_cmd_data;
    logic [ID_W-1:0]   bus_cmd_id;
    logic              snp_valid = 0, snp_write = 0;
    logic [ID_W-1:0]   snp_id = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              rsp_valid = 0;
    logic [ADDR_W-1:0] rsp_addr = '0;
    logic [DATA_W-1:0] rsp_data = '0;

    always #2.5 clk = ~clk;

    wt_snoop_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
                     .ID_W(ID_W), .MY_ID(MY_ID)) dut_i (.*);

    // Behavioural reference: cached words keyed by full address, plus memory.
    logic [DATA_W-1:0] model_c [int];
    logic [DATA_W-1:0] model_m [int];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    function automatic logic [DATA_W-1:0] mem_rd(int a);
        return model_m.exists(a) ? model_m[a] : DATA_W'(32'hA000_0000 + a * 7);
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic void install(int a, logic [DATA_W-1:0] d);
        int keys[$];
        foreach (model_c[k]) if ((k % (1 << IDX_W)) == (a % (1 << IDX_W))) keys.push_back(k);
        foreach (keys[i]) model_c.delete(keys[i]);
        model_c[a] = d;
    endfunction

    // Load; on a miss optionally snoops a foreign write to snp_a mid-fill (R11).
    task automatic do_load(int a, bit mid_snoop, int snp_a, string req);
        bit hit = model_c.exists(a);
        logic [DATA_W-1:0] d;
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = 0; cpu_req_addr = ADDR_W'(a);
        #1;
        chk(cpu_req_ready == 1, "R10 ready idle", 64'(cpu_req_ready), 1);
        if (hit) begin
            chk(cpu_rdata_valid && cpu_rdata == model_c[a], {req, " hit data"},
                64'(cpu_rdata), 64'(model_c[a]));
            chk(bus_req == 0, "R2 no bus on hit", 64'(bus_req), 0);
            @(negedge clk); cpu_req_valid = 0;
        end else begin
            chk(cpu_rdata_valid == 0, {req, " miss no data"}, 64'(cpu_rdata_valid), 0);
            @(negedge clk); cpu_req_valid = 0; #1;
            chk(bus_req && !cpu_req_ready, "R3 R10 req after miss",
                {62'd0, bus_req, cpu_req_ready}, 64'b10);
            chk(bus_cmd_valid == 0, "R10 no cmd without gnt", 64'(bus_cmd_valid), 0);
            @(negedge clk); bus_gnt = 1; #1;
            chk(bus_cmd_valid && !bus_cmd_write && bus_cmd_addr == ADDR_W'(a) &&
                bus_cmd_id == ID_W'(MY_ID), "R3 read cmd", 64'(bus_cmd_addr), 64'(a));
            @(negedge clk); bus_gnt = 0; #1;
            chk(!bus_cmd_valid && !cpu_req_ready && !bus_req, "R10 waiting fill",
                {61'd0, bus_cmd_valid, cpu_req_ready, bus_req}, 0);
            if (mid_snoop) begin
                snp_valid = 1; snp_write = 1; snp_id = 2; snp_addr = ADDR_W'(snp_a);
                model_m[snp_a] = 32'h5A5A_0000;
                if (model_c.exists(snp_a)) model_c.delete(snp_a);
                @(negedge clk); snp_valid = 0;
            end
            rsp_valid = 1; rsp_addr = ADDR_W'(a ^ 16'h0100); rsp_data = 32'hDEAD_BEEF;
            #1;
            chk(cpu_rdata_valid == 0, "R4 foreign rsp ignored", 64'(cpu_rdata_valid), 0);
            @(negedge clk);
            d = mem_rd(a);
            rsp_addr = ADDR_W'(a); rsp_data = d; #1;
            chk(cpu_rdata_valid && cpu_rdata == d, {req, " fill data"},
                64'(cpu_rdata), 64'(d));
            @(negedge clk); rsp_valid = 0;
            install(a, d);
        end
    endtask

    task automatic do_store(int a, logic [DATA_W-1:0] d);
        @(negedge clk);
        cpu_req_valid = 1; cpu_req_write = 1; cpu_req_addr = ADDR_W'(a); cpu_req_wdata = d;
        #1;
        chk(cpu_req_ready && !cpu_rdata_valid, "R5 store accepted", 64'(cpu_req_ready), 1);
        @(negedge clk); cpu_req_valid = 0; #1;
        chk(bus_req == 1, "R5 store requests bus", 64'(bus_req), 1);
        bus_gnt = 1; #1;
        chk(bus_cmd_valid && bus_cmd_write && bus_cmd_addr == ADDR_W'(a) &&
            bus_cmd_data == d, "R5 write cmd", 64'(bus_cmd_data), 64'(d));
        @(negedge clk); bus_gnt = 0; #1;
        chk(cpu_req_ready == 1, "R5 ready after write", 64'(cpu_req_ready), 1);
        model_m[a] = d;
        if (model_c.exists(a)) model_c[a] = d;
    endtask

    task automatic do_snoop(bit wr, int id, int a);
        @(negedge clk);
        snp_valid = 1; snp_write = wr; snp_id = ID_W'(id); snp_addr = ADDR_W'(a);
        @(negedge clk); snp_valid = 0;
        if (wr) model_m[a] = 32'hC0DE_0000 + a;
        if (wr && id != MY_ID && model_c.exists(a)) model_c.delete(a);
    endtask

    task automatic expect_miss(int a, string req);
        chk(!model_c.exists(a), {req, " model says miss"}, 0, 0);
        do_load(a, 0, 0, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        localparam int A = 16'h0012, C = 16'h0112, B = 16'h0035, D = 16'h0047;
        repeat (3) @(negedge clk);
        rst = 0; #1;
        // R1: reset state
        chk(cpu_req_ready && !bus_req && !bus_cmd_valid && !cpu_rdata_valid,
            "R1 reset outputs", {60'd0, cpu_req_ready, bus_req, bus_cmd_valid, cpu_rdata_valid}, 64'b1000);
        do_load(A, 0, 0, "R1 R3 R4");          // first load misses, fills
        do_load(A, 0, 0, "R2");                // hit
        do_store(A, 32'h1111_2222);            // store hit
        do_load(A, 0, 0, "R7");                // new data from local copy
        do_store(B, 32'h3333_4444);            // store miss
        expect_miss(B, "R6");                  // no allocation
        do_snoop(1, 1, A);                     // own write: ignored
        do_snoop(0, 3, A);                     // foreign read: ignored
        do_snoop(1, 2, C);                     // foreign write, tag mismatch: ignored
        do_load(A, 0, 0, "R9");                // still a hit
        do_snoop(1, 2, A);                     // foreign write hit
        expect_miss(A, "R8");
        do_load(C, 1, A, "R11");               // fill C while A (same index) snooped
        do_load(C, 0, 0, "R11 after");         // C present with fill data
        expect_miss(A, "R4 replaced");         // A evicted by C
        do_store(D, 32'h7777_0000);
        do_load(D, 0, 0, "R6 R4 mem");         // miss, fill returns stored memory
        do_load(D, 0, 0, "R2 again");
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule